// File: doc/BRIEF.md
# Byte-wide SRAM Bus Controller

This block models a byte-wide static memory behind an asynchronous, active-low control interface. The chip enable, output enable and write enable lines are sampled on a fast system clock, and the block turns them into read and write cycles. A read needs write enable high and both chip enable and output enable low. The returned byte is presented on a data output, together with a drive flag that takes the place of a tri-state pad.

A write window opens once chip enable and write enable are both low, so the later of the two falling edges starts it. The window shuts on the first of the two to rise. The byte is committed to the array at that closing edge, at the address captured when the window opened. After each write, write enable must stay high for a programmable number of clocks before any further cycle is accepted. A write-protect input from a power supervisor silences the whole interface.

The address width is a parameter. The default of 11 keeps elaboration small, and setting it to 15 gives the full 32,768-byte array.

Top module: `sram_bus_ctrl`

## Requirements
- R1: When ce_n and oe_n are sampled low and we_n high, with wr_prot low and no recovery pending, dout_en is high one clock later and dout carries the byte stored at addr; any other control combination leaves dout_en low one clock later.
- R2: The array holds 2^ADDR_W bytes of DATA_W bits each. Every address from 0 up to 2^ADDR_W-1 stores and returns its own byte.
- R3: A write window opens on the first clock at which ce_n and we_n are both sampled low, whichever of them fell last. The byte is committed when the window closes.
- R4: The window closes on the first clock at which either ce_n or we_n is sampled high. The committed byte is the din value sampled on the last clock the window was open. The address used is the one sampled when the window opened, and later addr changes have no effect on it.
- R5: A low we_n forces dout_en low on the next clock, even while ce_n and oe_n are low.
- R6: After a window commits, we_n must be sampled high on REC_CYC consecutive clocks before a new read or write is accepted. A we_n low during that interval is ignored and restarts the count. A read requested during it leaves dout_en low.
- R7: While wr_prot is high, no window opens, an open window is dropped without committing, and dout_en is low on the next clock.
- R8: Whenever dout_en is low, dout is all zeros.
- R9: Synchronous reset leaves dout_en low, dout zero, no window open and no recovery pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_prot | input | 1 | Write protect from the power supervisor, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drive flag standing in for the tri-state enable |

## Verification
The bench opens a window with write enable first and chip enable last, then changes both the data and the address while the window is open. A design that latched the data at the opening edge would store the wrong byte. A design that used the live address at the closing edge would write over a neighbouring location, which the bench reads back to catch.

The bench also retries a write and a read inside the recovery interval. A design without the hold-off would store the early byte or drive the bus too soon.

Finally, it raises write protect in the middle of an open window. A design that committed on that close would corrupt the array.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } bus_ctl_t;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

    function automatic logic wr_request(bus_ctl_t c);
        return !c.ce_n && !c.we_n;
    endfunction

    function automatic logic wr_release(bus_ctl_t c);
        return c.ce_n || c.we_n;
    endfunction

    function automatic logic rd_request(bus_ctl_t c);
        return !c.ce_n && !c.oe_n && c.we_n;
    endfunction

endpackage

// File: rtl/sram_recovery_timer.sv
module sram_recovery_timer #(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic we_n,
    input  logic wr_prot,
    output logic busy
);
    localparam int CW = $clog2(REC_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(REC_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (commit) begin
            cnt <= RELOAD;
        end else if (cnt != '0 && !we_n && !wr_prot) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_REC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && !we_n && !wr_prot) |=> busy); // R6

    AST_REC_ARMED: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy); // R6

endmodule

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ctl_t          ctl,
    input  logic              wr_prot,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data,
    output logic              rd_en
);
    win_state_e state;
    logic open_now;
    logic close_now;
    logic track;

    assign open_now  = (state == WIN_IDLE) && wr_request(ctl) && !wr_prot && !busy;
    assign close_now = (state == WIN_OPEN) && (wr_release(ctl) || wr_prot);
    assign track     = open_now || ((state == WIN_OPEN) && !close_now);
    assign commit    = (state == WIN_OPEN) && wr_release(ctl) && !wr_prot;
    assign rd_en     = (state == WIN_IDLE) && rd_request(ctl) && !wr_prot && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WIN_IDLE;
        end else if (open_now) begin
            state <= WIN_OPEN;
        end else if (close_now) begin
            state <= WIN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cm_addr <= '0;
            cm_data <= '0;
        end else begin
            if (open_now) cm_addr <= addr;
            if (track)    cm_data <= din;
        end
    end

    AST_WIN_SHUT: assert property (@(posedge clk) disable iff (rst)
        ((state == WIN_OPEN) && (ctl.ce_n || ctl.we_n)) |=> (state == WIN_IDLE)); // R4

    AST_WIN_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        (busy && state == WIN_IDLE) |=> (state == WIN_IDLE)); // R6

    AST_WP_NO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wr_prot |=> (state == WIN_IDLE)); // R7

    AST_WIN_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        ((state == WIN_OPEN) && !close_now) |=> $stable(cm_addr)); // R4

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? cells[raddr] : '0;
        end
    end

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0)); // R8

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(wr && rd)); // R1

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int REC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wr_prot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    bus_ctl_t          ctl;
    logic              busy;
    logic              commit;
    logic              rd_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_data;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    sram_recovery_timer #(
        .REC_CYC (REC_CYC)
    ) u_rec (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .we_n    (we_n),
        .wr_prot (wr_prot),
        .busy    (busy)
    );

    sram_cycle_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wr_prot (wr_prot),
        .busy    (busy),
        .addr    (addr),
        .din     (din),
        .commit  (commit),
        .cm_addr (cm_addr),
        .cm_data (cm_data),
        .rd_en   (rd_en)
    );

    sram_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (commit),
        .waddr  (cm_addr),
        .wdata  (cm_data),
        .rd     (rd_en),
        .raddr  (addr),
        .rdata  (dout),
        .rvalid (dout_en)
    );

    AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n || !we_n) |=> !dout_en); // R1

    AST_WE_KILLS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> !dout_en); // R5

    AST_WP_SILENT: assert property (@(posedge clk) disable iff (rst)
        wr_prot |=> !dout_en); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!dout_en && dout == '0)); // R9

endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;
    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 8;
    localparam int REC_CYC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic              wr_prot = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_en;

    int total = 0;
    int fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REC_CYC (REC_CYC)
    ) u_sram_bus_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .wr_prot (wr_prot),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        step();
        step();
        bus_idle();
        step();
        repeat (REC_CYC + 1) step();
    endtask

    task automatic rd_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step();
        chk(dout_en == 1'b1, req, int'(dout_en), 1);
        chk(dout == e, req, int'(dout), int'(e));
        bus_idle();
        step();
        chk(dout_en == 1'b0 && dout == '0, "R8", int'(dout), 0);
    endtask

    task automatic t_reset();
        chk(dout_en == 1'b0, "R9", int'(dout_en), 0);
        chk(dout == '0, "R9", int'(dout), 0);
    endtask

    task automatic t_basic();
        wr_byte(11'h000, 8'hA5);
        wr_byte(11'h7FF, 8'h3C);
        wr_byte(11'h155, 8'h96);
        rd_byte(11'h000, 8'hA5, "R2");
        rd_byte(11'h7FF, 8'h3C, "R2");
        rd_byte(11'h155, 8'h96, "R1");
        addr = 11'h155; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        step();
        chk(dout_en == 1'b0, "R1", int'(dout_en), 0);
        bus_idle();
        step();
    endtask

    task automatic t_ce_late();
        wr_byte(11'h0B0, 8'h44);
        addr = 11'h0A0; din = 8'hEE; we_n = 1'b0; ce_n = 1'b1;
        step();
        ce_n = 1'b0; din = 8'h11;
        step();
        addr = 11'h0B0; din = 8'h22;
        step();
        ce_n = 1'b1;
        step();
        we_n = 1'b1;
        repeat (REC_CYC + 1) step();
        rd_byte(11'h0A0, 8'h22, "R4");
        rd_byte(11'h0B0, 8'h44, "R4");
    endtask

    task automatic t_we_kill();
        addr = 11'h033; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        step();
        chk(dout_en == 1'b1, "R5", int'(dout_en), 1);
        din = 8'hC3; we_n = 1'b0;
        step();
        chk(dout_en == 1'b0, "R5", int'(dout_en), 0);
        chk(dout == '0, "R8", int'(dout), 0);
        bus_idle();
        step();
        repeat (REC_CYC + 1) step();
        rd_byte(11'h033, 8'hC3, "R3");
    endtask

    task automatic t_recovery();
        wr_byte(11'h0C0, 8'h10);
        addr = 11'h0C1; din = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
        step();
        step();
        bus_idle();
        step();
        addr = 11'h0C1; ce_n = 1'b0; oe_n = 1'b0;
        step();
        chk(dout_en == 1'b0, "R6", int'(dout_en), 0);
        repeat (REC_CYC) step();
        chk(dout_en == 1'b1, "R6", int'(dout_en), 1);
        chk(dout == 8'h5A, "R6", int'(dout), 8'h5A);
        bus_idle();
        step();
        addr = 11'h0C2; din = 8'h01; ce_n = 1'b0; we_n = 1'b0;
        step();
        step();
        bus_idle();
        step();
        step();
        addr = 11'h0C0; din = 8'h77; ce_n = 1'b0; we_n = 1'b0;
        step();
        step();
        bus_idle();
        repeat (REC_CYC + 2) step();
        rd_byte(11'h0C0, 8'h10, "R6");
    endtask

    task automatic t_protect();
        wr_byte(11'h0D0, 8'h33);
        wr_prot = 1'b1;
        addr = 11'h0D0; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
        step();
        step();
        we_n = 1'b1; oe_n = 1'b0;
        step();
        chk(dout_en == 1'b0, "R7", int'(dout_en), 0);
        bus_idle();
        wr_prot = 1'b0;
        step();
        rd_byte(11'h0D0, 8'h33, "R7");
        addr = 11'h0D0; din = 8'h99; ce_n = 1'b0; we_n = 1'b0;
        step();
        wr_prot = 1'b1;
        step();
        bus_idle();
        step();
        wr_prot = 1'b0;
        step();
        rd_byte(11'h0D0, 8'h33, "R7");
    endtask

    initial begin
        #(CLK_P * 50000);
        total++;
        fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        step();
        t_basic();
        t_ce_late();
        t_we_kill();
        t_recovery();
        t_protect();
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    end

endmodule